// File: doc/BRIEF.md
# Transmit-Direction Cell Tag Stripper

This block sits between a switch fabric's byte stream and a PHY transmit port that carries fixed-size cells. Each incoming cell carries 52 bytes of cell body (a 4-byte header and a 48-byte payload, with no HEC byte) plus a tag of zero to four bytes. The tag sits either before or after the body. The block removes the tag. When configured, it opens a one-byte HEC slot after the header, and it can carry the PT/CLP bits from a leading 4-byte tag into the header.

The block buffers one whole cell before it releases any byte. This lets it make two decisions per cell before the cell goes out. The first decision is whether the subport address is valid. The second is what to do when the PHY reports its FIFO full. On a full FIFO the block can discard the cell, wait as long as needed, or wait for a programmed number of cycles and then discard. While the block holds a cell it lowers its input-ready signal, so the stall reaches back into the upstream pipeline.

Top module: `tag_strip_tx`

## Requirements
- R1: With `cfg_tag_len` = N (0 to 4), each input cell is N+52 bytes long and the block removes the N tag bytes. Values above 4 act as 4.
- R2: With `cfg_tag_at_end` = 0, the tag is the first N bytes of the input cell. With `cfg_tag_at_end` = 1, it is the last N bytes. In both cases the 52 body bytes leave in input order.
- R3: With `cfg_hec_add` = 1, the block inserts the byte 0x00 as the fifth output byte, so the output cell has 53 bytes. With `cfg_hec_add` = 0, the output cell has 52 bytes and no byte is added.
- R4: When `cfg_move_ptclp` = 1, `cfg_tag_at_end` = 0 and the tag length is 4, output header byte 3 bits [3:0] are replaced by bits [3:0] of the last tag byte. With any other setting, header byte 3 leaves unchanged.
- R5: The subport address is bits [7:3] of header byte 0. If it exceeds `cfg_max_sub` and `cfg_drop_inval` = 1, no byte of the cell is output and `drop_inval` pulses for one cycle. If `cfg_drop_inval` = 0, the cell passes.
- R6: With `cfg_stall_mode` = 0 or 3, a cell that finds `phy_full` high when it is ready to leave is discarded and `drop_full` pulses once.
- R7: With `cfg_stall_mode` = 1, a cell that finds `phy_full` high is held, with `in_ready` low and no output, until `phy_full` falls. It is then sent in full.
- R8: With `cfg_stall_mode` = 2, the cell waits at most `cfg_stall_cycles`+1 cycles. It is sent if `phy_full` falls within that window. Otherwise it is discarded and `drop_full` pulses once.
- R9: `out_soc` is high on the first output byte of each cell and on no other byte. The bytes of one cell leave on consecutive cycles.
- R10: An input byte with `in_soc` high starts a new cell, even when a previous cell is incomplete. Bytes without `in_soc` outside a cell are ignored. `in_ready` is low from the cycle after a cell's last byte until that cell has been sent or discarded.
- R11: After reset, `out_valid`, `drop_inval` and `drop_full` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_soc | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| cfg_tag_len | input | 3 | Tag length in bytes, 0 to 4 |
| cfg_tag_at_end | input | 1 | 0: tag leads the cell, 1: tag trails it |
| cfg_hec_add | input | 1 | Insert a HEC placeholder byte |
| cfg_move_ptclp | input | 1 | Copy PT/CLP from the leading tag into the header |
| cfg_drop_inval | input | 1 | Discard cells with an out-of-range subport |
| cfg_max_sub | input | SUB_W | Highest valid subport address |
| cfg_stall_mode | input | 2 | 0/3 discard, 1 wait indefinitely, 2 wait with a bound |
| cfg_stall_cycles | input | CNT_W | Wait bound for mode 2 |
| phy_full | input | 1 | PHY transmit FIFO cannot take a cell |
| out_valid | output | 1 | Output byte valid |
| out_soc | output | 1 | Output byte is the first byte of a cell |
| out_data | output | 8 | Output byte |
| drop_inval | output | 1 | One-cycle pulse: cell discarded for its subport |
| drop_full | output | 1 | One-cycle pulse: cell discarded for a full FIFO |

## Verification
The embedded assertions check the following on every cycle. `out_soc` never appears without a valid byte, and a cell's bytes never break up. The two discard pulses never coincide, and a subport discard never occurs while that check is disabled. The mode-2 wait counter never passes its bound, and mode 1 never discards. After a cell's last byte, `in_ready` always falls. Only the bench scenarios can show that byte content is right: tag removal at both positions and all lengths, placement of the HEC slot, substitution of the PT/CLP nibble, and which subport values pass. The same holds for whether a held cell is eventually delivered intact or correctly discarded.

// File: rtl/tst_pkg.sv
package tst_pkg;
  typedef enum logic [1:0] {
    EG_FILL = 2'd0,
    EG_EVAL = 2'd1,
    EG_WAIT = 2'd2,
    EG_SEND = 2'd3
  } eg_state_t;

  localparam logic [1:0] STALL_DROP  = 2'd0;
  localparam logic [1:0] STALL_HOLD  = 2'd1;
  localparam logic [1:0] STALL_TIMED = 2'd2;

  localparam int HDR_BYTES    = 4;
  localparam int PTCLP_TAG_SZ = 4;
endpackage

// File: rtl/tst_cellbuf.sv
module tst_cellbuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 52,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tst_ingress.sv
module tst_ingress #(
  parameter int CELL_BYTES = 52,
  parameter int TAG_MAX    = 4,
  parameter int SUB_W      = 5,
  parameter int AW         = 6,
  parameter int PW         = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_valid,
  input  logic             in_soc,
  input  logic [7:0]       in_data,
  input  logic [2:0]       tag_len,
  input  logic             tag_at_end,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             cell_done,
  output logic [SUB_W-1:0] sub_q,
  output logic [3:0]       ptclp_q
);
  logic [PW-1:0] pos, cur, tlen, lead, last, bidx;
  logic          in_cell, take, in_body, lead_last;

  always_comb begin
    tlen      = (int'(tag_len) > TAG_MAX) ? PW'(TAG_MAX) : PW'(tag_len);
    lead      = tag_at_end ? '0 : tlen;
    last      = PW'(CELL_BYTES) + tlen - PW'(1);
    take      = en & in_valid & (in_soc | in_cell);
    cur       = in_soc ? '0 : pos;
    bidx      = cur - lead;
    in_body   = (cur >= lead) && (bidx < PW'(CELL_BYTES));
    wr_en     = take & in_body;
    wr_addr   = bidx[AW-1:0];
    wr_data   = in_data;
    cell_done = take && (cur == last);
    lead_last = take && !tag_at_end && (tlen != '0) && (cur == tlen - PW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      in_cell <= 1'b0;
      sub_q   <= '0;
      ptclp_q <= '0;
    end else begin
      if (take) begin
        if (cell_done) begin
          pos     <= '0;
          in_cell <= 1'b0;
        end else begin
          pos     <= cur + PW'(1);
          in_cell <= 1'b1;
        end
      end
      if (wr_en && bidx == '0) sub_q <= in_data[7 -: SUB_W];
      if (lead_last) ptclp_q <= in_data[3:0];
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < CELL_BYTES)); // R1
endmodule

// File: rtl/tst_egress.sv
module tst_egress
  import tst_pkg::*;
#(
  parameter int         CELL_BYTES = 52,
  parameter int         SUB_W      = 5,
  parameter int         CNT_W      = 8,
  parameter int         AW         = 6,
  parameter logic [7:0] HEC_FILL   = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_done,
  input  logic [SUB_W-1:0] sub,
  input  logic [3:0]       ptclp,
  input  logic [2:0]       tag_len,
  input  logic             tag_at_end,
  input  logic             hec_add,
  input  logic             move_ptclp,
  input  logic             drop_inval_en,
  input  logic [SUB_W-1:0] max_sub,
  input  logic [1:0]       stall_mode,
  input  logic [CNT_W-1:0] stall_cycles,
  input  logic             phy_full,
  output logic             fill_en,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [7:0]       rd_q,
  output logic             out_valid,
  output logic             out_soc,
  output logic [7:0]       out_data,
  output logic             drop_inval,
  output logic             drop_full
);
  localparam int OW = $clog2(CELL_BYTES + 2);

  eg_state_t      state;
  logic [OW-1:0]  idx, olast, ridx, s1_idx;
  logic [CNT_W-1:0] wait_cnt;
  logic           bad, waits, timed_out, s1_valid, mv;

  always_comb begin
    olast     = hec_add ? OW'(CELL_BYTES) : OW'(CELL_BYTES - 1);
    bad       = drop_inval_en && (sub > max_sub);
    waits     = (stall_mode == STALL_HOLD) || (stall_mode == STALL_TIMED);
    timed_out = (stall_mode != STALL_HOLD) && (wait_cnt >= stall_cycles);
    mv        = move_ptclp && !tag_at_end && (int'(tag_len) >= PTCLP_TAG_SZ);
    fill_en   = (state == EG_FILL);
    rd_en     = (state == EG_SEND);
    ridx      = (hec_add && idx > OW'(HDR_BYTES)) ? idx - OW'(1) : idx;
    rd_addr   = ridx[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= EG_FILL;
      idx        <= '0;
      wait_cnt   <= '0;
      drop_inval <= 1'b0;
      drop_full  <= 1'b0;
    end else begin
      drop_inval <= 1'b0;
      drop_full  <= 1'b0;
      case (state)
        EG_FILL: if (cell_done) state <= EG_EVAL;
        EG_EVAL: begin
          idx      <= '0;
          wait_cnt <= '0;
          if (bad) begin
            drop_inval <= 1'b1;
            state      <= EG_FILL;
          end else if (!phy_full) begin
            state <= EG_SEND;
          end else if (waits) begin
            state <= EG_WAIT;
          end else begin
            drop_full <= 1'b1;
            state     <= EG_FILL;
          end
        end
        EG_WAIT: begin
          if (!phy_full) begin
            state <= EG_SEND;
          end else if (timed_out) begin
            drop_full <= 1'b1;
            state     <= EG_FILL;
          end else if (stall_mode == STALL_TIMED) begin
            wait_cnt <= wait_cnt + CNT_W'(1);
          end
        end
        EG_SEND: begin
          if (idx == olast) state <= EG_FILL;
          else              idx   <= idx + OW'(1);
        end
        default: state <= EG_FILL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_idx    <= '0;
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
      out_data  <= '0;
    end else begin
      s1_valid  <= (state == EG_SEND);
      s1_idx    <= idx;
      out_valid <= s1_valid;
      out_soc   <= s1_valid && (s1_idx == '0);
      if (hec_add && s1_idx == OW'(HDR_BYTES))
        out_data <= HEC_FILL;
      else if (mv && s1_idx == OW'(HDR_BYTES - 1))
        out_data <= {rd_q[7:4], ptclp};
      else
        out_data <= rd_q;
    end
  end

  AST_DROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(drop_inval && drop_full)); // R5
  AST_INVAL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    drop_inval |-> drop_inval_en); // R5
  AST_HOLD_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    (state == EG_WAIT && stall_mode == STALL_HOLD && $stable(stall_mode)) |=> !drop_full); // R7
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == EG_WAIT && stall_mode == STALL_TIMED) |-> (wait_cnt <= stall_cycles)); // R8
  AST_SOC_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_soc |-> out_valid); // R9
  AST_CELL_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_soc) |-> $past(out_valid)); // R9
endmodule

// File: rtl/tag_strip_tx.sv
module tag_strip_tx #(
  parameter int         CELL_BYTES = 52,
  parameter int         TAG_MAX    = 4,
  parameter int         SUB_W      = 5,
  parameter int         CNT_W      = 8,
  parameter logic [7:0] HEC_FILL   = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_soc,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic [2:0]       cfg_tag_len,
  input  logic             cfg_tag_at_end,
  input  logic             cfg_hec_add,
  input  logic             cfg_move_ptclp,
  input  logic             cfg_drop_inval,
  input  logic [SUB_W-1:0] cfg_max_sub,
  input  logic [1:0]       cfg_stall_mode,
  input  logic [CNT_W-1:0] cfg_stall_cycles,
  input  logic             phy_full,
  output logic             out_valid,
  output logic             out_soc,
  output logic [7:0]       out_data,
  output logic             drop_inval,
  output logic             drop_full
);
  localparam int AW = $clog2(CELL_BYTES);
  localparam int PW = $clog2(CELL_BYTES + TAG_MAX + 1);

  logic             wr_en, rd_en, cell_done, fill_en;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [7:0]       wr_data, rd_q;
  logic [SUB_W-1:0] sub_q;
  logic [3:0]       ptclp_q;

  assign in_ready = fill_en;

  tst_ingress #(
    .CELL_BYTES(CELL_BYTES), .TAG_MAX(TAG_MAX), .SUB_W(SUB_W), .AW(AW), .PW(PW)
  ) ingress_i (
    .clk(clk), .rst(rst), .en(fill_en),
    .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data),
    .tag_len(cfg_tag_len), .tag_at_end(cfg_tag_at_end),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cell_done(cell_done), .sub_q(sub_q), .ptclp_q(ptclp_q)
  );

  tst_cellbuf #(.DW(8), .DEPTH(CELL_BYTES), .AW(AW)) buf_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_q)
  );

  tst_egress #(
    .CELL_BYTES(CELL_BYTES), .SUB_W(SUB_W), .CNT_W(CNT_W), .AW(AW), .HEC_FILL(HEC_FILL)
  ) egress_i (
    .clk(clk), .rst(rst), .cell_done(cell_done), .sub(sub_q), .ptclp(ptclp_q),
    .tag_len(cfg_tag_len), .tag_at_end(cfg_tag_at_end), .hec_add(cfg_hec_add),
    .move_ptclp(cfg_move_ptclp), .drop_inval_en(cfg_drop_inval), .max_sub(cfg_max_sub),
    .stall_mode(cfg_stall_mode), .stall_cycles(cfg_stall_cycles), .phy_full(phy_full),
    .fill_en(fill_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(rd_q),
    .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data),
    .drop_inval(drop_inval), .drop_full(drop_full)
  );

  AST_READY_DROPS_AFTER_CELL: assert property (@(posedge clk) disable iff (rst)
    cell_done |=> !in_ready); // R10
endmodule

// File: tb/tag_strip_tx_tb_top.sv
module tag_strip_tx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_soc = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic [2:0] cfg_tag_len = '0;
  logic cfg_tag_at_end = 0, cfg_hec_add = 0, cfg_move_ptclp = 0, cfg_drop_inval = 0;
  logic [4:0] cfg_max_sub = 5'd31;
  logic [1:0] cfg_stall_mode = 2'd0;
  logic [7:0] cfg_stall_cycles = 8'd6;
  logic phy_full = 1'b0;
  logic out_valid, out_soc, drop_inval, drop_full;
  logic [7:0] out_data;

  int vecs = 0, fails = 0;
  logic [7:0] exp_d[$], pend_d[$];
  bit exp_s[$], pend_s[$];
  string exp_r[$], pend_r[$];
  int exp_drop[$];

  always #5 clk = ~clk;

  tag_strip_tx dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data),
    .in_ready(in_ready), .cfg_tag_len(cfg_tag_len), .cfg_tag_at_end(cfg_tag_at_end),
    .cfg_hec_add(cfg_hec_add), .cfg_move_ptclp(cfg_move_ptclp),
    .cfg_drop_inval(cfg_drop_inval), .cfg_max_sub(cfg_max_sub),
    .cfg_stall_mode(cfg_stall_mode), .cfg_stall_cycles(cfg_stall_cycles),
    .phy_full(phy_full), .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data),
    .drop_inval(drop_inval), .drop_full(drop_full)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  // per-clock comparison against the reference queues
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_d.size() == 0) begin
          check(0, "R9", "unexpected output byte", int'(out_data), 0);
        end else begin
          check(out_data == exp_d[0], exp_r[0], "out_data", int'(out_data), int'(exp_d[0]));
          check(out_soc == exp_s[0], "R9", "out_soc", int'(out_soc), int'(exp_s[0]));
          void'(exp_d.pop_front()); void'(exp_s.pop_front()); void'(exp_r.pop_front());
        end
      end
      if (drop_inval) begin
        check(exp_drop.size() > 0 && exp_drop[0] == 1, "R5", "drop_inval pulse", 1,
              exp_drop.size() > 0 ? exp_drop[0] : 0);
        if (exp_drop.size() > 0) void'(exp_drop.pop_front());
      end
      if (drop_full) begin
        check(exp_drop.size() > 0 && exp_drop[0] == 2, "R6", "drop_full pulse", 2,
              exp_drop.size() > 0 ? exp_drop[0] : 0);
        if (exp_drop.size() > 0) void'(exp_drop.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] d, input bit s);
    in_valid = 1'b1; in_data = d; in_soc = s;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_soc = 1'b0;
  endtask

  // outcome: 0 sent, 1 subport drop, 2 full drop, 3 sent later (deferred)
  task automatic run_cell(input int tl, input bit [4:0] sub, input bit [3:0] ptc,
                          input bit gaps, input int outcome, input string req);
    logic [7:0] body[52];
    logic [7:0] tag[4];
    logic [7:0] q[$];
    bit mv;
    for (int i = 0; i < 52; i++) body[i] = 8'($urandom);
    body[0] = {sub, body[0][2:0]};
    for (int i = 0; i < 4; i++) tag[i] = 8'($urandom);
    if (tl > 0) tag[tl-1][3:0] = ptc;
    mv = cfg_move_ptclp && !cfg_tag_at_end && tl == 4;
    for (int i = 0; i < 52; i++) begin
      if (i == 3 && mv) q.push_back({body[3][7:4], ptc});
      else q.push_back(body[i]);
      if (i == 3 && cfg_hec_add) q.push_back(8'h00);
    end
    if (outcome == 0 || outcome == 3) begin
      for (int i = 0; i < q.size(); i++) begin
        if (outcome == 0) begin exp_d.push_back(q[i]); exp_s.push_back(i == 0); exp_r.push_back(req); end
        else begin pend_d.push_back(q[i]); pend_s.push_back(i == 0); pend_r.push_back(req); end
      end
    end else begin
      exp_drop.push_back(outcome);
    end
    for (int i = 0; i < tl + 52; i++) begin
      logic [7:0] b;
      if (!cfg_tag_at_end) b = (i < tl) ? tag[i] : body[i-tl];
      else b = (i < 52) ? body[i] : tag[i-52];
      if (gaps && (i % 7) == 3) idle(1);
      put(b, i == 0);
    end
  endtask

  task automatic release_pending();
    while (pend_d.size() > 0) begin
      exp_d.push_back(pend_d.pop_front());
      exp_s.push_back(pend_s.pop_front());
      exp_r.push_back(pend_r.pop_front());
    end
  endtask

  task automatic cfg(input int tl, input bit at_end, input bit hec, input bit mv);
    cfg_tag_len = 3'(tl); cfg_tag_at_end = at_end; cfg_hec_add = hec; cfg_move_ptclp = mv;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0, "R11", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1, "R11", "in_ready after reset", int'(in_ready), 1);
    check(drop_inval == 0 && drop_full == 0, "R11", "drop pulses after reset",
          int'({drop_inval, drop_full}), 0);
    @(posedge clk); #1;

    // R1: no tag, no HEC slot
    cfg(0, 0, 0, 0); run_cell(0, 5'd3, 4'h0, 0, 0, "R1"); idle(80);
    // R1 R3: leading 4-byte tag, HEC slot, input gaps
    cfg(4, 0, 1, 0); run_cell(4, 5'd7, 4'h9, 1, 0, "R3"); idle(80);
    // R2: trailing 2-byte tag
    cfg(2, 1, 0, 0); run_cell(2, 5'd1, 4'h0, 0, 0, "R2"); idle(80);
    // R2: trailing 4-byte tag with HEC slot
    cfg(4, 1, 1, 0); run_cell(4, 5'd2, 4'h0, 1, 0, "R2"); idle(80);
    // R4: move PT/CLP from leading 4-byte tag
    cfg(4, 0, 0, 1); run_cell(4, 5'd4, 4'hA, 0, 0, "R4"); idle(80);
    // R4: trailing tag: no effect
    cfg(4, 1, 0, 1); run_cell(4, 5'd4, 4'h5, 0, 0, "R4"); idle(80);
    // R4: 3-byte leading tag: no effect
    cfg(3, 0, 1, 1); run_cell(3, 5'd4, 4'h6, 0, 0, "R4"); idle(80);

    // R5: subport check
    cfg(1, 0, 0, 0); cfg_max_sub = 5'd10; cfg_drop_inval = 1;
    run_cell(1, 5'd11, 4'h0, 0, 1, "R5"); idle(80);
    run_cell(1, 5'd10, 4'h0, 0, 0, "R5"); idle(80);
    cfg_drop_inval = 0;
    run_cell(1, 5'd31, 4'h0, 0, 0, "R5"); idle(80);
    cfg_max_sub = 5'd31;

    // R6: discard on full, modes 0 and 3
    cfg(0, 0, 0, 0); phy_full = 1; cfg_stall_mode = 2'd0;
    run_cell(0, 5'd0, 4'h0, 0, 2, "R6"); idle(20);
    cfg_stall_mode = 2'd3;
    run_cell(0, 5'd0, 4'h0, 0, 2, "R6"); idle(20);
    phy_full = 0; idle(20);

    // R7: hold indefinitely
    cfg_stall_mode = 2'd1; phy_full = 1;
    run_cell(0, 5'd2, 4'h0, 0, 3, "R7");
    idle(300);
    @(negedge clk);
    check(in_ready == 0, "R7", "in_ready while holding", int'(in_ready), 0);
    @(posedge clk); #1;
    release_pending(); phy_full = 0; idle(80);

    // R8: bounded wait expires
    cfg_stall_mode = 2'd2; cfg_stall_cycles = 8'd6; phy_full = 1;
    run_cell(0, 5'd2, 4'h0, 0, 2, "R8"); idle(40);
    // R8: full clears inside window
    run_cell(0, 5'd2, 4'h0, 0, 3, "R8");
    idle(3);
    @(negedge clk);
    check(in_ready == 0, "R8", "in_ready during timed wait", int'(in_ready), 0);
    @(posedge clk); #1;
    release_pending(); phy_full = 0; idle(80);
    cfg_stall_mode = 2'd0;

    // R10: stray bytes without start marker are ignored
    cfg(2, 0, 1, 0);
    put(8'h11, 0); put(8'h22, 0); put(8'h33, 0);
    run_cell(2, 5'd5, 4'h0, 0, 0, "R10"); idle(80);
    // R10: a new start marker restarts an unfinished cell
    for (int i = 0; i < 10; i++) put(8'(8'hC0 + i), i == 0);
    run_cell(2, 5'd6, 4'h0, 1, 0, "R10"); idle(80);

    check(exp_d.size() == 0, "R9", "bytes still expected", exp_d.size(), 0);
    check(exp_drop.size() == 0, "R5", "drops still expected", exp_drop.size(), 0);
    finish_run();
  end
endmodule